// File: doc/BRIEF.md
# Memory Card SPI-Mode Initialization Sequencer

This block takes a memory card that has just been powered and walks it into SPI mode, then reports which card generation it found and whether later data commands must carry block numbers or byte offsets. It does not shift bits itself. It orders a separate command engine through each step: a burst of wake-up clocks with select and data-in held high, a software reset, an interface-condition probe, repeated operation-condition polling, an OCR read and a block-length setting. It keeps the serial clock on the slow rate until the card is usable, and only then selects the fast rate.

The sequencer sends the engine a one-cycle request and waits for a one-cycle completion pulse. The completion carries the first reply byte, the 32-bit word that follows it for the long-reply commands, and a flag for "no reply seen". A single `start` pulse runs the whole sequence. The sequence ends with `ready` or with `error`, and both hold until the next `start`. Polling is bounded by a count of idle replies rather than by time, so the limit follows the card's behaviour and not the clock rate.

Top module: `sdi_init_seq`

## Requirements
- R1: After reset, `ready`, `error`, `fast_clk` and `block_addr` are 0, `card_type` is 0, and neither `wake_go` nor `cmd_go` is asserted until `start` is seen.
- R2: A `start` pulse accepted while idle, done or failed produces exactly one `wake_go` pulse before any command. `wake_len` asks for more than 74 clocks, and no `cmd_go` appears until `wake_done` has returned.
- R3: The first command has index 0, argument 0, CRC byte 0x95 and a short reply. A reply of exactly 0x01 continues the sequence. Any other reply ends it with `error`.
- R4: The second command has index 8, argument 0x000001AA, CRC byte 0x87 and a long reply. A reply byte with bit 2 (illegal command) set selects the older-card path. A reply of 0x01 whose trailing word has 0x1AA in bits 11:0 selects the second-generation path. Anything else ends in `error`.
- R5: Application initialization is index 55 (argument 0) followed by index 41. The index-41 argument is 0x40000000 on the second-generation path and 0 on the older path.
- R6: A reply of 0x01 to the initialization command repeats it (index 55 then 41, or index 1 alone). A reply of 0x00 ends the polling.
- R7: A reply with bit 2 set to index 55 or index 41 switches to polling with index 1 (argument 0). The card then finishes with `card_type` 0 (legacy).
- R8: `POLL_LIMIT` idle replies to the initialization command end the sequence with `error` and no further commands. `POLL_LIMIT`−1 idle replies followed by 0x00 still succeed.
- R9: On the second-generation path, the index-58 long-reply command follows initialization. Bit 30 of its word set gives `card_type` 3 and `block_addr` 1, with no block-length command. Bit 30 clear gives `card_type` 2.
- R10: Every card except type 3 receives index 16 with argument 512 before finishing. A reply of 0x00 gives `ready`. Any other reply gives `error`. Type codes are 0 legacy, 1 first generation and 2 second-generation standard capacity.
- R11: `fast_clk` rises only together with `ready`. It stays 0 while the sequence runs and after `error`.
- R12: A missing reply (`rsp_none`) at any step ends the sequence with `error`. In the error state `ready` is 0 and no further commands are issued.
- R13: `start` is ignored while a sequence runs. A new `start` after done or failure clears `ready`, `error`, `fast_clk`, `card_type` and `block_addr` and reruns from the wake-up clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse to begin the initialization sequence |
| wake_go | output | 1 | One-cycle request for the wake-up clock burst |
| wake_len | output | $clog2(WAKE_CLOCKS+1) | Number of wake-up clocks requested |
| wake_done | input | 1 | Pulse from the engine when the burst has finished |
| cmd_go | output | 1 | One-cycle request to send a command frame |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | CRC byte of the frame, including the end bit |
| cmd_long | output | 1 | A 32-bit word follows the reply byte |
| cmd_done | input | 1 | Pulse from the engine when the reply is available |
| rsp_r1 | input | 8 | First reply byte |
| rsp_word | input | 32 | Trailing reply word, valid when `cmd_long` was set |
| rsp_none | input | 1 | No reply arrived within the response window |
| fast_clk | output | 1 | 1 selects the fast serial clock |
| ready | output | 1 | Card initialized |
| error | output | 1 | Sequence failed |
| card_type | output | 2 | 0 legacy, 1 first generation, 2 second-generation standard, 3 second-generation high capacity |
| block_addr | output | 1 | Data commands must use block numbers |

## Verification
The bench plays the command engine with scripted replies and goes after the branch points. If the interface-probe echo check were dropped, a mismatched 0x1AB echo would still reach `ready`. If bit 30 of the index-41 argument were misplaced, the second-generation log would show the wrong argument. If the fallback were wrong, an illegal reply to index 55 or 41 would stall or fail instead of moving to index-1 polling. At the poll limit the bench runs both `POLL_LIMIT`−1 idle replies followed by success and `POLL_LIMIT` idle replies; an off-by-one counter gets one of the two wrong. It also checks that a high-capacity card skips the block-length command, that a rejected block length fails, and that a second `start` during a run adds no wake burst.

// File: rtl/sdi_pkg.sv
// Shared types and constants for the card SPI-mode initialization sequencer.
// Assumes replies follow the single-byte status layout: bit 0 idle, bit 2 illegal command.
package sdi_pkg;

    // Top-level activity of the sequencer
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WAKE_GO,
        PH_WAKE_WAIT,
        PH_SEND,
        PH_WAIT,
        PH_DONE,
        PH_FAIL
    } phase_t;

    // Which command the sequencer is on
    typedef enum logic [2:0] {
        ST_RESET,
        ST_IFCOND,
        ST_APPCMD,
        ST_APPINIT,
        ST_OPINIT,
        ST_READOCR,
        ST_BLKLEN
    } step_t;

    // Reported card generation
    typedef enum logic [1:0] {
        CARD_LEGACY = 2'd0,
        CARD_V1     = 2'd1,
        CARD_V2_STD = 2'd2,
        CARD_V2_HC  = 2'd3
    } card_t;

    // One command frame handed to the engine
    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
        logic [7:0]  crc;
        logic        long_rsp;
    } cmd_frame_t;

    localparam logic [7:0]  R1_IDLE      = 8'h01;
    localparam logic [7:0]  R1_READY     = 8'h00;
    localparam int          R1_ILLEGAL   = 2;
    localparam int          R1_START_BIT = 7;
    localparam logic [11:0] IF_ECHO      = 12'h1AA;
    localparam int          CAP_BIT      = 30;
    localparam int          BLOCK_BYTES  = 512;
    localparam logic [7:0]  CRC_RESET    = 8'h95;
    localparam logic [7:0]  CRC_IFCOND   = 8'h87;
    localparam logic [7:0]  CRC_DONTCARE = 8'h01;

endpackage

// File: rtl/sdi_cmd_build.sv
// Builds the command frame for the current step of the sequence.
// Assumes CRC is only checked by the card on the reset and interface-probe commands;
// the other frames carry just the end bit in the CRC byte.
module sdi_cmd_build
    import sdi_pkg::*;
(
    input  step_t      step,
    input  logic       gen2,
    output cmd_frame_t frame
);

    // Select index, argument, CRC and reply length for each step
    always_comb begin : frame_select
        frame = '{index: 6'd0, arg: 32'd0, crc: CRC_DONTCARE, long_rsp: 1'b0};
        unique case (step)
            ST_RESET:   frame = '{index: 6'd0,  arg: 32'd0, crc: CRC_RESET, long_rsp: 1'b0};
            ST_IFCOND:  frame = '{index: 6'd8,  arg: {20'd0, IF_ECHO}, crc: CRC_IFCOND, long_rsp: 1'b1};
            ST_APPCMD:  frame = '{index: 6'd55, arg: 32'd0, crc: CRC_DONTCARE, long_rsp: 1'b0};
            ST_APPINIT: frame = '{index: 6'd41, arg: (gen2 ? (32'd1 << CAP_BIT) : 32'd0),
                                  crc: CRC_DONTCARE, long_rsp: 1'b0};
            ST_OPINIT:  frame = '{index: 6'd1,  arg: 32'd0, crc: CRC_DONTCARE, long_rsp: 1'b0};
            ST_READOCR: frame = '{index: 6'd58, arg: 32'd0, crc: CRC_DONTCARE, long_rsp: 1'b1};
            ST_BLKLEN:  frame = '{index: 6'd16, arg: 32'(BLOCK_BYTES), crc: CRC_DONTCARE, long_rsp: 1'b0};
            default:    frame = '{index: 6'd0,  arg: 32'd0, crc: CRC_RESET, long_rsp: 1'b0};
        endcase
    end

endmodule

// File: rtl/sdi_reply_class.sv
// Classifies a reply from the command engine into the few cases the sequencer branches on.
// Assumes a reply with the top bit set is not a valid status byte.
module sdi_reply_class
    import sdi_pkg::*;
(
    input  logic [7:0]  r1,
    input  logic [31:0] word,
    input  logic        none,
    output logic        is_idle,
    output logic        is_ready,
    output logic        is_illegal,
    output logic        echo_ok,
    output logic        cap_set
);

    logic unused_word_bits;

    // Decode the status byte and the fields of the trailing word
    always_comb begin : classify
        is_idle    = !none && (r1 == R1_IDLE);
        is_ready   = !none && (r1 == R1_READY);
        is_illegal = !none && r1[R1_ILLEGAL] && !r1[R1_START_BIT];
        echo_ok    = (word[11:0] == IF_ECHO);
        cap_set    = word[CAP_BIT];
    end

    assign unused_word_bits = ^{word[31], word[29:12]};

endmodule

// File: rtl/sdi_poll_timer.sv
// Counts idle replies during initialization polling and flags the last allowed one.
// Assumes clr and bump are never asserted in the same cycle.
module sdi_poll_timer #(
    parameter int LIMIT = 20000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Advance the idle-reply count, cleared at each new sequence
    always_ff @(posedge clk) begin : count_polls
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (bump && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(LIMIT - 1));

    assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/sdi_init_seq.sv
// Card SPI-mode initialization sequencer. Orders a command engine through wake-up
// clocks, reset, interface probe, bounded initialization polling with fallback,
// OCR read and block-length setting, then reports card type and addressing mode.
// Assumes the engine answers each request with exactly one done pulse, at least
// one cycle after the request.
module sdi_init_seq
    import sdi_pkg::*;
#(
    parameter int POLL_LIMIT  = 20000,
    parameter int WAKE_CLOCKS = 80,
    localparam int WAKE_W     = $clog2(WAKE_CLOCKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              wake_go,
    output logic [WAKE_W-1:0] wake_len,
    input  logic              wake_done,
    output logic              cmd_go,
    output logic [5:0]        cmd_index,
    output logic [31:0]       cmd_arg,
    output logic [7:0]        cmd_crc,
    output logic              cmd_long,
    input  logic              cmd_done,
    input  logic [7:0]        rsp_r1,
    input  logic [31:0]       rsp_word,
    input  logic              rsp_none,
    output logic              fast_clk,
    output logic              ready,
    output logic              error,
    output logic [1:0]        card_type,
    output logic              block_addr
);

    phase_t     phase;
    step_t      step;
    logic       gen2, legacy, woke;
    logic       ready_q, error_q, fast_q, blk_q;
    card_t      type_q;
    cmd_frame_t frame;

    logic is_idle, is_ready, is_illegal, echo_ok, cap_set;
    logic poll_last, poll_bump, take_start, reply_in;
    logic dec_fail, dec_done, set_gen2, set_legacy, set_hc;
    step_t dec_step;
    card_t done_type;

    sdi_cmd_build u_build (
        .step  (step),
        .gen2  (gen2),
        .frame (frame)
    );

    sdi_reply_class u_class (
        .r1         (rsp_r1),
        .word       (rsp_word),
        .none       (rsp_none),
        .is_idle    (is_idle),
        .is_ready   (is_ready),
        .is_illegal (is_illegal),
        .echo_ok    (echo_ok),
        .cap_set    (cap_set)
    );

    sdi_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_start),
        .bump  (reply_in && poll_bump),
        .last  (poll_last)
    );

    assign take_start = start && (phase == PH_IDLE || phase == PH_DONE || phase == PH_FAIL);
    assign reply_in   = (phase == PH_WAIT) && cmd_done;

    // Decide the next step from the reply to the current command
    always_comb begin : reply_decode
        dec_fail   = 1'b0;
        dec_done   = 1'b0;
        dec_step   = step;
        set_gen2   = 1'b0;
        set_legacy = 1'b0;
        set_hc     = 1'b0;
        poll_bump  = 1'b0;
        unique case (step)
            ST_RESET: begin
                if (is_idle) dec_step = ST_IFCOND;
                else         dec_fail = 1'b1;
            end
            ST_IFCOND: begin
                if (is_illegal) begin
                    dec_step = ST_APPCMD;
                end else if (is_idle && echo_ok) begin
                    set_gen2 = 1'b1;
                    dec_step = ST_APPCMD;
                end else begin
                    dec_fail = 1'b1;
                end
            end
            ST_APPCMD: begin
                if (is_illegal) begin
                    set_legacy = 1'b1;
                    dec_step   = ST_OPINIT;
                end else if (is_idle || is_ready) begin
                    dec_step = ST_APPINIT;
                end else begin
                    dec_fail = 1'b1;
                end
            end
            ST_APPINIT: begin
                if (is_ready) begin
                    dec_step = gen2 ? ST_READOCR : ST_BLKLEN;
                end else if (is_idle) begin
                    if (poll_last) begin
                        dec_fail = 1'b1;
                    end else begin
                        poll_bump = 1'b1;
                        dec_step  = ST_APPCMD;
                    end
                end else if (is_illegal) begin
                    set_legacy = 1'b1;
                    dec_step   = ST_OPINIT;
                end else begin
                    dec_fail = 1'b1;
                end
            end
            ST_OPINIT: begin
                if (is_ready) begin
                    dec_step = ST_BLKLEN;
                end else if (is_idle && !poll_last) begin
                    poll_bump = 1'b1;
                end else begin
                    dec_fail = 1'b1;
                end
            end
            ST_READOCR: begin
                if (is_ready && cap_set) begin
                    set_hc   = 1'b1;
                    dec_done = 1'b1;
                end else if (is_ready) begin
                    dec_step = ST_BLKLEN;
                end else begin
                    dec_fail = 1'b1;
                end
            end
            ST_BLKLEN: begin
                if (is_ready) dec_done = 1'b1;
                else          dec_fail = 1'b1;
            end
            default: dec_fail = 1'b1;
        endcase
    end

    // Work out the type to report when the sequence completes
    always_comb begin : type_select
        if (legacy)      done_type = CARD_LEGACY;
        else if (!gen2)  done_type = CARD_V1;
        else if (set_hc) done_type = CARD_V2_HC;
        else             done_type = CARD_V2_STD;
    end

    // Main sequencing register: phase, step, path flags and results
    always_ff @(posedge clk) begin : seq_main
        if (!rst_n) begin
            phase   <= PH_IDLE;
            step    <= ST_RESET;
            gen2    <= 1'b0;
            legacy  <= 1'b0;
            woke    <= 1'b0;
            ready_q <= 1'b0;
            error_q <= 1'b0;
            fast_q  <= 1'b0;
            blk_q   <= 1'b0;
            type_q  <= CARD_LEGACY;
        end else begin
            unique case (phase)
                PH_IDLE, PH_DONE, PH_FAIL: begin
                    if (take_start) begin
                        phase   <= PH_WAKE_GO;
                        step    <= ST_RESET;
                        gen2    <= 1'b0;
                        legacy  <= 1'b0;
                        woke    <= 1'b0;
                        ready_q <= 1'b0;
                        error_q <= 1'b0;
                        fast_q  <= 1'b0;
                        blk_q   <= 1'b0;
                        type_q  <= CARD_LEGACY;
                    end
                end
                PH_WAKE_GO: phase <= PH_WAKE_WAIT;
                PH_WAKE_WAIT: begin
                    if (wake_done) begin
                        woke  <= 1'b1;
                        step  <= ST_RESET;
                        phase <= PH_SEND;
                    end
                end
                PH_SEND: phase <= PH_WAIT;
                PH_WAIT: begin
                    if (cmd_done) begin
                        if (dec_fail) begin
                            phase   <= PH_FAIL;
                            error_q <= 1'b1;
                        end else if (dec_done) begin
                            phase   <= PH_DONE;
                            ready_q <= 1'b1;
                            fast_q  <= 1'b1;
                            type_q  <= done_type;
                            blk_q   <= set_hc;
                        end else begin
                            step  <= dec_step;
                            phase <= PH_SEND;
                            if (set_gen2) gen2 <= 1'b1;
                            if (set_legacy) begin
                                legacy <= 1'b1;
                                gen2   <= 1'b0;
                            end
                        end
                    end
                end
                default: phase <= PH_FAIL;
            endcase
        end
    end

    assign wake_go    = (phase == PH_WAKE_GO);
    assign wake_len   = WAKE_W'(WAKE_CLOCKS);
    assign cmd_go     = (phase == PH_SEND);
    assign cmd_index  = frame.index;
    assign cmd_arg    = frame.arg;
    assign cmd_crc    = frame.crc;
    assign cmd_long   = frame.long_rsp;
    assign fast_clk   = fast_q;
    assign ready      = ready_q;
    assign error      = error_q;
    assign card_type  = type_q;
    assign block_addr = blk_q;

    assert_wake_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> woke);
    assert_one_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_go, wake_go}));
    assert_reset_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_index == 6'd0) |-> (cmd_crc == CRC_RESET));
    assert_probe_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd_index == 6'd8) |-> (cmd_crc == CRC_IFCOND && cmd_long));
    assert_go_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);
    assert_blk_hc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_addr |-> (card_type == 2'd3));
    assert_fast_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clk |-> ready);
    assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && error));
    assert_quiet_fail_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> !cmd_go);

endmodule

// File: tb/tb_sdi_init_seq.sv
`timescale 1ns/1ps
module tb_sdi_init_seq;

    localparam int LIMIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wake_go, wake_done = 1'b0;
    logic [6:0]  wake_len;
    logic        cmd_go, cmd_long, cmd_done = 1'b0;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg, rsp_word = '0;
    logic [7:0]  cmd_crc, rsp_r1 = '0;
    logic        rsp_none = 1'b0;
    logic        fast_clk, ready, error, block_addr;
    logic [1:0]  card_type;

    sdi_init_seq #(.POLL_LIMIT(LIMIT), .WAKE_CLOCKS(80)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .wake_go(wake_go), .wake_len(wake_len), .wake_done(wake_done),
        .cmd_go(cmd_go), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
        .cmd_long(cmd_long), .cmd_done(cmd_done), .rsp_r1(rsp_r1), .rsp_word(rsp_word),
        .rsp_none(rsp_none), .fast_clk(fast_clk), .ready(ready), .error(error),
        .card_type(card_type), .block_addr(block_addr)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Scripted replies and command log of the engine model
    logic [7:0]  scr_r1   [0:15];
    logic [31:0] scr_word [0:15];
    logic        scr_none [0:15];
    logic [5:0]  log_idx  [0:15];
    logic [31:0] log_arg  [0:15];
    logic [7:0]  log_crc  [0:15];
    logic        log_long [0:15];
    int  ncmd = 0, wake_seen = 0, wake_len_seen = 0, pend_c = 0, pend_w = 0, pend_idx = 0;
    bit  early_cmd = 0;
    bit  clr_on_start = 1;

    // Engine model: logs requests at the falling edge and answers three cycles later
    always @(negedge clk) begin
        cmd_done  = 1'b0;
        wake_done = 1'b0;
        if (start && clr_on_start) begin
            ncmd = 0; wake_seen = 0; early_cmd = 0;
        end
        if (pend_w > 0) begin
            pend_w--;
            if (pend_w == 0) wake_done = 1'b1;
        end
        if (pend_c > 0) begin
            pend_c--;
            if (pend_c == 0) begin
                cmd_done = 1'b1;
                if (pend_idx < 16) begin
                    rsp_r1 = scr_r1[pend_idx]; rsp_word = scr_word[pend_idx]; rsp_none = scr_none[pend_idx];
                end else begin
                    rsp_r1 = 8'hFF; rsp_word = '0; rsp_none = 1'b1;
                end
            end
        end
        if (wake_go) begin
            wake_seen++;
            wake_len_seen = int'(wake_len);
            pend_w = 3;
        end
        if (cmd_go) begin
            if (wake_seen == 0) early_cmd = 1;
            if (ncmd < 16) begin
                log_idx[ncmd] = cmd_index; log_arg[ncmd] = cmd_arg;
                log_crc[ncmd] = cmd_crc;   log_long[ncmd] = cmd_long;
            end
            pend_idx = ncmd;
            ncmd++;
            pend_c = 3;
        end
    end

    // Watchdog: an expired run is a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_script();
        for (int i = 0; i < 16; i++) begin
            scr_r1[i] = 8'h00; scr_word[i] = '0; scr_none[i] = 1'b0;
        end
    endtask

    task automatic put(input int i, input logic [7:0] r1, input logic [31:0] w);
        scr_r1[i] = r1; scr_word[i] = w;
    endtask

    task automatic launch();
        @(negedge clk); #2 start = 1'b1;
        @(negedge clk); #2 start = 1'b0;
    endtask

    task automatic wait_end();
        int n = 0;
        while (!(ready || error) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_result(input string req, input bit exp_ready, input int exp_n,
                                input logic [1:0] exp_type, input bit exp_blk);
        chk({req, " ready"}, ready, exp_ready);
        chk({req, " error"}, error, !exp_ready);
        chk({req, " fast_clk R11"}, fast_clk, exp_ready);
        chk({req, " command count"}, ncmd, exp_n);
        if (exp_ready) begin
            chk({req, " card_type"}, card_type, exp_type);
            chk({req, " block_addr"}, block_addr, exp_blk);
        end
    endtask

    task automatic t_reset_state();
        chk("R1 ready", ready, 0);
        chk("R1 error", error, 0);
        chk("R1 fast_clk", fast_clk, 0);
        chk("R1 card_type", card_type, 0);
        chk("R1 block_addr", block_addr, 0);
        repeat (5) @(negedge clk);
        chk("R1 no requests", ncmd + wake_seen, 0);
    endtask

    task automatic t_v2_high_cap();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h01, 32'h000001AA);
        put(2, 8'h01, 0); put(3, 8'h01, 0); put(4, 8'h01, 0); put(5, 8'h00, 0);
        put(6, 8'h00, 32'hC0FF8000);
        launch();
        repeat (2) @(negedge clk);
        chk("R11 slow while running", fast_clk, 0);
        wait_end();
        chk("R2 one wake burst", wake_seen, 1);
        chk("R2 wake length over 74", wake_len_seen > 74, 1);
        chk("R2 no command before wake", early_cmd, 0);
        chk("R3 reset index", log_idx[0], 0);
        chk("R3 reset crc", log_crc[0], 8'h95);
        chk("R3 reset short", log_long[0], 0);
        chk("R4 probe index", log_idx[1], 8);
        chk("R4 probe arg", log_arg[1], 32'h1AA);
        chk("R4 probe crc", log_crc[1], 8'h87);
        chk("R4 probe long", log_long[1], 1);
        chk("R5 app prefix", log_idx[2], 55);
        chk("R5 init index", log_idx[3], 41);
        chk("R5 HCS argument", log_arg[3], 32'h40000000);
        chk("R6 poll repeats prefix", log_idx[4], 55);
        chk("R9 OCR index", log_idx[6], 58);
        chk("R9 OCR long", log_long[6], 1);
        check_result("R9 high capacity", 1, 7, 2'd3, 1);
    endtask

    task automatic t_v2_standard();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h01, 32'h000001AA); put(2, 8'h01, 0); put(3, 8'h00, 0);
        put(4, 8'h00, 32'h80FF8000); put(5, 8'h00, 0);
        launch();
        wait_end();
        chk("R10 block length index", log_idx[5], 16);
        chk("R10 block length arg", log_arg[5], 512);
        check_result("R9 standard capacity", 1, 6, 2'd2, 0);
    endtask

    task automatic t_v1();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0); put(2, 8'h01, 0); put(3, 8'h00, 0); put(4, 8'h00, 0);
        launch();
        wait_end();
        chk("R5 first-gen init index", log_idx[3], 41);
        chk("R5 first-gen argument", log_arg[3], 0);
        chk("R10 block length index", log_idx[4], 16);
        check_result("R4 first-gen", 1, 5, 2'd1, 0);
    endtask

    task automatic t_legacy_prefix();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0); put(2, 8'h05, 0);
        put(3, 8'h01, 0); put(4, 8'h00, 0); put(5, 8'h00, 0);
        launch();
        wait_end();
        chk("R7 fallback index", log_idx[3], 1);
        chk("R7 fallback arg", log_arg[3], 0);
        chk("R6 CMD1 repeats", log_idx[4], 1);
        check_result("R7 legacy via prefix", 1, 6, 2'd0, 0);
    endtask

    task automatic t_legacy_init();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0); put(2, 8'h01, 0); put(3, 8'h05, 0);
        put(4, 8'h00, 0); put(5, 8'h00, 0);
        launch();
        wait_end();
        chk("R7 fallback after init reject", log_idx[4], 1);
        check_result("R7 legacy via init", 1, 6, 2'd0, 0);
    endtask

    task automatic t_echo_bad();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h01, 32'h000001AB);
        launch();
        wait_end();
        check_result("R4 echo mismatch", 0, 2, 2'd0, 0);
    endtask

    task automatic t_reset_bad();
        clear_script();
        put(0, 8'h00, 0);
        launch();
        wait_end();
        check_result("R3 wrong reset reply", 0, 1, 2'd0, 0);
        clear_script();
        scr_none[0] = 1'b1;
        launch();
        wait_end();
        check_result("R12 no reply", 0, 1, 2'd0, 0);
        chk("R12 card_type after error", card_type, 0);
    endtask

    task automatic t_poll_edge();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0);
        for (int i = 2; i < 9; i++) put(i, 8'h01, 0);
        put(9, 8'h00, 0); put(10, 8'h00, 0);
        launch();
        wait_end();
        check_result("R8 limit minus one", 1, 11, 2'd1, 0);
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0);
        for (int i = 2; i < 16; i++) put(i, 8'h01, 0);
        launch();
        wait_end();
        check_result("R8 timeout", 0, 10, 2'd0, 0);
    endtask

    task automatic t_blklen_reject();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0); put(2, 8'h01, 0); put(3, 8'h00, 0); put(4, 8'h40, 0);
        launch();
        wait_end();
        check_result("R10 block length rejected", 0, 5, 2'd0, 0);
    endtask

    task automatic t_busy_start();
        clear_script();
        put(0, 8'h01, 0); put(1, 8'h05, 0); put(2, 8'h01, 0); put(3, 8'h00, 0); put(4, 8'h00, 0);
        launch();
        repeat (8) @(negedge clk);
        clr_on_start = 0;
        #2 start = 1'b1;
        @(negedge clk); #2 start = 1'b0;
        wait_end();
        clr_on_start = 1;
        chk("R13 busy start wake count", wake_seen, 1);
        check_result("R13 busy start ignored", 1, 5, 2'd1, 0);
        launch();
        chk("R13 restart clears ready", ready, 0);
        chk("R13 restart clears fast_clk", fast_clk, 0);
        chk("R13 restart clears type", card_type, 0);
        wait_end();
    endtask

    initial begin
        clear_script();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_v2_high_cap();
        t_v2_standard();
        t_v1();
        t_legacy_prefix();
        t_legacy_init();
        t_echo_bad();
        t_reset_bad();
        t_poll_edge();
        t_blklen_reject();
        t_v1();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule